// File: doc/BRIEF.md
# Configuration Bitstream Streaming Host

This block sits on the host side of a configuration link and loads an image into a target device, one word at a time, over a valid-qualified stream with target-driven backpressure. A `start` pulse with a word count begins a load. The block first runs a reset handshake with the target. It pulls its active-low request line low and waits for the target's active-low status line to fall. It then releases the request line and waits for status to rise again. Only after that does it begin streaming.

While streaming, each word comes from a local source through a ready/valid interface and is passed straight to the target with a valid strobe. The target's ready line is asynchronous to the streaming clock, so it is only used after a two-flop synchronizer. Because of that delay, the host can still send a few words after the target withdraws ready. A post-drop counter caps those words so that no more than six land after the raw ready falls.

When the programmed count has gone out, the block pulses `done` for one cycle. If status falls in mid-stream, the block stops sending, raises a sticky `error` and returns to idle. The streaming clock is expected to run continuously for the whole load.

Top module: `cfg_stream_host`

## Requirements
- R1: While reset is held, `cfg_req_n` is 1 and `tgt_valid`, `src_ready`, `done` and `error` are 0.
- R2: A `start` pulse in idle drives `cfg_req_n` to 0, and it stays 0 for as long as the synchronized status line stays high.
- R3: `cfg_req_n` returns to 1 on the third rising edge after `cfg_status_n` falls (two synchronizer edges plus one state edge). No word is sent while status is still low.
- R4: After the handshake, no word is sent until the synchronized target ready has been seen high, even when the source holds words.
- R5: `tgt_ready` passes through exactly two flops. With the stream armed and the source valid, a rise of `tgt_ready` first shows on `tgt_valid` after the second rising edge.
- R6: After the raw `tgt_ready` falls, at most six words are sent: two during synchronizer latency and `POST_DROP` (4 by default) counted after the synchronized fall. The count restarts each time ready returns high. With a source that is always valid, exactly six are sent.
- R7: A word leaves the source only in a cycle where `tgt_valid` is 1 (`src_ready` equals `tgt_valid`), and `tgt_data` carries `src_data` unchanged, so the target receives the source order.
- R8: Exactly `word_count` words are sent. Then `done` is 1 for exactly one cycle, and `tgt_valid` stays 0 afterwards.
- R9: If status falls while streaming, sending stops, `error` goes to 1 and the block returns to idle with `cfg_req_n` at 1. `error` holds until the next `start`, which clears it.
- R10: A `start` pulse while a load is in progress is ignored.
- R11: A `word_count` of 0 completes with a `done` pulse after the handshake, sends no word, and does not wait for target ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Streaming clock, free-running |
| rst | input | 1 | Active-high reset (synchronous for control, asynchronous clear of synchronizer flops) |
| start | input | 1 | Begin a load; sampled only in idle |
| word_count | input | CNT_W | Number of words to send, captured on `start` |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| cfg_status_n | input | 1 | Active-low status from the target, asynchronous |
| src_data | input | DATA_W | Word offered by the local source |
| src_valid | input | 1 | Source holds a word |
| src_ready | output | 1 | Source word consumed this cycle |
| tgt_data | output | DATA_W | Word driven to the target |
| tgt_valid | output | 1 | `tgt_data` is a word for the target |
| tgt_ready | input | 1 | Target backpressure, asynchronous |
| done | output | 1 | One-cycle pulse when the full count has been sent |
| error | output | 1 | Status fell during streaming; held until next `start` |

## Verification
The bench builds the block with an 8-bit data path, a 6-bit word counter and a post-drop budget of 4. The short counter makes it practical to sweep every word count from 0 to 10, each with a gap-free and a gapped source and a ready duty cycle that changes with the count. The small budget, added to the two synchronizer stages, sits exactly at the six-word ceiling, so a forced ready drop must yield precisely six trailing words. Dedicated runs pin the cycle of request release and of the first word after ready rises. They also cover an abort by status in mid-stream and a stray `start` during a load.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    // Depth of the clock-crossing chain on target inputs.
    localparam int SYNC_STAGES = 2;
    // Words the target tolerates after it withdraws ready.
    localparam int TRAIL_MAX   = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_REL    = 2'd2,
        ST_STREAM = 2'd3
    } cfg_state_e;

    function automatic bit width_ok(input int w);
        return (w == 8) || (w == 16) || (w == 32);
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Flops clear immediately on reset, without waiting for a clock.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

    if (STAGES == 2) begin : g_chk
        // R5
        sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
            dout |-> $past(din, 2));
    end

endmodule

// File: rtl/cfg_burst_limit.sv
module cfg_burst_limit #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic rdy_s,
    input  logic sent,
    output logic allow
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Outside streaming the budget is spent, so a fresh load needs ready first.
    always_ff @(posedge clk) begin
        if (rst)                        cnt <= LIM_V;
        else if (arm)                   cnt <= LIM_V;
        else if (rdy_s)                 cnt <= '0;
        else if (sent && cnt < LIM_V)   cnt <= cnt + CW'(1);
    end

    assign allow = rdy_s || (cnt < LIM_V);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM_V);

    // R6
    trail_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!arm && !rdy_s && sent) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_stream_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] word_count,
    input  logic             stat_ok,
    input  logic             allow,
    input  logic             src_valid,
    output logic             req_n,
    output logic             arm,
    output logic             fire,
    output logic             done,
    output logic             error
);

    cfg_state_e       state;
    logic [CNT_W-1:0] remain;

    assign req_n = (state != ST_REQ);
    assign arm   = (state != ST_STREAM);
    assign fire  = (state == ST_STREAM) && stat_ok && allow && src_valid
                   && (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            done   <= 1'b0;
            error  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        remain <= word_count;
                        error  <= 1'b0;
                        state  <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (!stat_ok) state <= ST_REL;
                end
                ST_REL: begin
                    if (stat_ok) state <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (!stat_ok) begin
                        error <= 1'b1;
                        state <= ST_IDLE;
                    end else if (remain == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (fire) begin
                        remain <= remain - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    release_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_n) |-> !$past(stat_ok));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STREAM && !stat_ok) |=> (error && state == ST_IDLE && !fire));

endmodule

// File: rtl/cfg_stream_host.sv
module cfg_stream_host
    import cfg_stream_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int POST_DROP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_count,
    output logic              cfg_req_n,
    input  logic              cfg_status_n,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [DATA_W-1:0] tgt_data,
    output logic              tgt_valid,
    input  logic              tgt_ready,
    output logic              done,
    output logic              error
);

    if (!width_ok(DATA_W)) begin : g_bad_width
        $error("DATA_W must be 8, 16 or 32");
    end
    if (POST_DROP + SYNC_STAGES > TRAIL_MAX || POST_DROP < 1) begin : g_bad_budget
        $error("POST_DROP plus synchronizer depth exceeds trailing word limit");
    end

    logic rdy_s;
    logic stat_ok;
    logic allow;
    logic arm;
    logic fire;

    cfg_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (tgt_ready),
        .dout (rdy_s)
    );

    cfg_sync #(.STAGES(SYNC_STAGES)) u_stat_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cfg_status_n),
        .dout (stat_ok)
    );

    cfg_burst_limit #(.LIMIT(POST_DROP)) u_limit (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .rdy_s (rdy_s),
        .sent  (fire),
        .allow (allow)
    );

    cfg_seq_fsm #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .word_count (word_count),
        .stat_ok    (stat_ok),
        .allow      (allow),
        .src_valid  (src_valid),
        .req_n      (cfg_req_n),
        .arm        (arm),
        .fire       (fire),
        .done       (done),
        .error      (error)
    );

    assign tgt_data  = src_data;
    assign tgt_valid = fire;
    assign src_ready = fire;

endmodule

// File: tb/cfg_stream_host_test.sv
`timescale 1ns/1ps
module cfg_stream_host_test;

    localparam int DW    = 8;
    localparam int CW    = 6;
    localparam int PD    = 4;
    localparam int TRAIL = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] word_count = '0;
    logic          cfg_req_n;
    logic          cfg_status_n = 1'b1;
    logic [DW-1:0] src_data = '0;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [DW-1:0] tgt_data;
    logic          tgt_valid;
    logic          rdy_raw = 1'b0;
    logic          done;
    logic          error;

    cfg_stream_host #(.DATA_W(DW), .CNT_W(CW), .POST_DROP(PD)) uut (
        .clk(clk), .rst(rst), .start(start), .word_count(word_count),
        .cfg_req_n(cfg_req_n), .cfg_status_n(cfg_status_n),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .tgt_data(tgt_data), .tgt_valid(tgt_valid), .tgt_ready(rdy_raw),
        .done(done), .error(error)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0, seq = 0, exp_seq = 0;
    bit took = 0, gap_mode = 0, rdy_auto = 0, prev_done = 0;
    int r_hi = 1, r_per = 1;
    int xfer_cnt = 0, trail = 0, max_trail = 0, done_cnt = 0;
    int dbl = 0, data_bad = 0, rdy_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Source and ready pattern, driven just after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (took) seq++;
        src_valid = gap_mode ? ((cyc % 3) != 1) : 1'b1;
        src_data  = DW'(seq);
        if (rdy_auto) rdy_raw = ((cyc % r_per) < r_hi);
    end

    // Target model, sampled mid-cycle: values here are what the next edge takes.
    always @(negedge clk) begin
        took = src_ready;
        if (src_ready !== tgt_valid) rdy_bad++;
        if (tgt_valid === 1'b1) begin
            xfer_cnt++;
            if (tgt_data !== DW'(exp_seq)) data_bad++;
            exp_seq++;
        end
        if (rdy_raw) trail = 0;
        else if (tgt_valid === 1'b1) trail++;
        if (trail > max_trail) max_trail = trail;
        if (done === 1'b1) begin
            done_cnt++;
            if (prev_done) dbl++;
        end
        prev_done = (done === 1'b1);
    end

    task automatic clr();
        xfer_cnt = 0; trail = 0; max_trail = 0; done_cnt = 0;
        dbl = 0; data_bad = 0; rdy_bad = 0;
    endtask

    task automatic handshake(input int n, input bit hold_low);
        @(posedge clk); #1;
        clr();
        rdy_auto = 0; rdy_raw = 1'b0; cfg_status_n = 1'b1;
        start = 1'b1; word_count = CW'(n);
        @(posedge clk); #1;
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(cfg_req_n == 1'b0, "R2 request held low", cfg_req_n, 0);
        chk(error == 1'b0, "R9 error cleared by start", error, 0);
        @(posedge clk); #1;
        cfg_status_n = 1'b0;
        rdy_raw = !hold_low;
        repeat (3) @(negedge clk);
        chk(cfg_req_n == 1'b0, "R3 release waits for synced status", cfg_req_n, 0);
        @(negedge clk);
        chk(cfg_req_n == 1'b1, "R3 request released", cfg_req_n, 1);
        repeat (6) @(negedge clk);
        chk(xfer_cnt == 0, "R3 no word while status low", xfer_cnt, 0);
        @(posedge clk); #1;
        cfg_status_n = 1'b1;
    endtask

    task automatic finish_run(input int n);
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(xfer_cnt == n, "R8 word count", xfer_cnt, n);
        chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
        chk(dbl == 0, "R8 done lasts one cycle", dbl, 0);
        chk(data_bad == 0, "R7 data order", data_bad, 0);
        chk(rdy_bad == 0, "R7 source consumed only with valid", rdy_bad, 0);
        chk(max_trail <= TRAIL, "R6 trailing words bounded", max_trail, TRAIL);
        chk(tgt_valid == 1'b0, "R8 valid low after done", tgt_valid, 0);
        chk(cfg_req_n == 1'b1, "R8 idle after done", cfg_req_n, 1);
    endtask

    task automatic sweep_run(input int n, input bit gap, input bit poke);
        gap_mode = gap;
        handshake(n, 1'b0);
        r_per = 4 + (n % 4);
        r_hi  = 2 + (n % 3);
        rdy_auto = 1;
        if (poke) begin
            for (int i = 0; i < 500 && xfer_cnt < 4; i++) @(negedge clk);
            @(posedge clk); #1; start = 1'b1; word_count = CW'(3);
            @(posedge clk); #1; start = 1'b0;
            // R10: a start during the load must not change the word count
        end
        finish_run(n);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(cfg_req_n == 1'b1, "R10 stray start ignored", cfg_req_n, 1);
        end
    endtask

    task automatic ready_gate_run();
        gap_mode = 0;
        handshake(12, 1'b1);
        repeat (10) @(negedge clk);
        chk(xfer_cnt == 0, "R4 no word before ready", xfer_cnt, 0);
        @(posedge clk); #1;
        rdy_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(tgt_valid == 1'b0, "R5 not visible after one edge", tgt_valid, 0);
        @(negedge clk);
        chk(tgt_valid == 1'b1, "R5 visible after two edges", tgt_valid, 1);
        finish_run(12);
    endtask

    task automatic drop_run();
        int snap;
        gap_mode = 0;
        handshake(40, 1'b0);
        for (int i = 0; i < 500 && xfer_cnt < 3; i++) @(negedge clk);
        @(posedge clk); #1; rdy_raw = 1'b0;
        repeat (12) @(negedge clk);
        chk(trail == TRAIL, "R6 exactly six words after drop", trail, TRAIL);
        snap = xfer_cnt;
        repeat (5) @(negedge clk);
        chk(xfer_cnt == snap, "R6 stalled at budget", xfer_cnt, snap);
        @(posedge clk); #1; rdy_raw = 1'b1;
        repeat (6) @(negedge clk);
        @(posedge clk); #1; rdy_raw = 1'b0;
        repeat (12) @(negedge clk);
        chk(trail == TRAIL, "R6 budget renewed after ready", trail, TRAIL);
        @(posedge clk); #1; rdy_raw = 1'b1;
        finish_run(40);
    endtask

    task automatic abort_run();
        int snap;
        gap_mode = 0;
        handshake(40, 1'b0);
        for (int i = 0; i < 500 && xfer_cnt < 5; i++) @(negedge clk);
        @(posedge clk); #1; cfg_status_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(error == 1'b1, "R9 error raised", error, 1);
        chk(cfg_req_n == 1'b1, "R9 back to idle", cfg_req_n, 1);
        snap = xfer_cnt;
        repeat (6) @(negedge clk);
        chk(xfer_cnt == snap, "R9 sending stopped", xfer_cnt, snap);
        chk(xfer_cnt < 40, "R9 load cut short", xfer_cnt, 40);
        chk(done_cnt == 0, "R9 no done on abort", done_cnt, 0);
        chk(error == 1'b1, "R9 error held", error, 1);
        chk(data_bad == 0, "R7 data order before abort", data_bad, 0);
        @(posedge clk); #1; cfg_status_n = 1'b1;
    endtask

    task automatic empty_run();
        gap_mode = 0;
        handshake(0, 1'b1);
        for (int i = 0; i < 100 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R11 done with zero words and no ready", done_cnt, 1);
        chk(xfer_cnt == 0, "R11 no words sent", xfer_cnt, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(cfg_req_n == 1'b1, "R1 request idle", cfg_req_n, 1);
        chk(tgt_valid == 1'b0, "R1 valid low", tgt_valid, 0);
        chk(src_ready == 1'b0, "R1 source idle", src_ready, 0);
        chk(done == 1'b0, "R1 done low", done, 0);
        chk(error == 1'b0, "R1 error low", error, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (3) @(posedge clk);

        empty_run();
        ready_gate_run();
        drop_run();
        abort_run();
        for (int n = 0; n <= 10; n++) begin
            for (int g = 0; g < 2; g++) begin
                sweep_run(n, g[0], 1'b0);
            end
        end
        sweep_run(30, 1'b1, 1'b1);
        sweep_run(20, 1'b0, 1'b1);

        summary();
        $finish;
    end

endmodule